// File: doc/BRIEF.md
# SPI Loopback Test Controller

This block is a bench-top test sequencer for checking an SPI master core against an SPI slave core whose serial pins are wired to each other outside the chip. The user works it with two buttons. The mode button walks through four modes. The action button does something different in each mode:

- it steps the word the slave will send back;
- it hands that word to the slave core;
- it steps the word the master will send;
- it hands the slave its word again and starts a one-word master transfer in the same press.

The words each core receives are captured and held. A four-digit multiplexed seven-segment display shows all four values, and a lit decimal point marks the active mode.

The sequencer has four named states:

- `MODE_SLV_SET` (mode 0)
- `MODE_SLV_ARM` (mode 1)
- `MODE_MST_SET` (mode 2)
- `MODE_XFER` (mode 3)

A mode press takes `MODE_SLV_SET` to `MODE_SLV_ARM`, `MODE_SLV_ARM` to `MODE_MST_SET`, `MODE_MST_SET` to `MODE_XFER`, and `MODE_XFER` back to `MODE_SLV_SET`. No other event changes the state. Handing a word to a core uses a pending flag. The action press sets the flag, and the flag turns into a one-cycle valid strobe in the first cycle in which that core reports ready. The reset input comes from the board reset button and clears everything.

Top module: `spi_loop_tester`

## Requirements
- R1: The reset input is synchronous and active high. After reset the mode is 0, both transmit words and both captured words are 0, no valid strobe is asserted, and every digit shows 0.
- R2: Each accepted mode press advances the mode by one, wrapping from 3 to 0. The mode does not change without a mode press.
- R3: In mode 0, each accepted action press increments the slave transmit word (`slv_tx_data`) by one, modulo 16.
- R4: In mode 1, an accepted action press produces exactly one single-cycle `slv_tx_vld` carrying the current slave word. Neither word changes.
- R5: In mode 2, each accepted action press increments the master transmit word (`mst_tx_data`) by one, modulo 16.
- R6: In mode 3, an accepted action press produces one `slv_tx_vld` and one `mst_tx_vld`. `mst_tx_last` is high whenever `mst_tx_vld` is high.
- R7: A valid strobe is never asserted while the matching ready is low. A load or transfer requested while ready is low is issued once ready returns high.
- R8: `slv_rx_data` and `mst_rx_data` are captured only in cycles where their valid input is high, and are held otherwise. Data that arrives without its valid has no effect.
- R9: The digit with index 0, 1, 2 and 3 (enabled by `dig_n[i]` low) shows, in that order: the slave transmit word, the slave received word, the master transmit word and the master received word. `seg_n` is {g,f,e,d,c,b,a}, active low, in standard hex glyphs.
- R10: `dp_n` is low exactly while the digit whose index equals the mode is enabled.
- R11: A button level that lasts fewer than `DEB_CYCLES` synchronised cycles is ignored. A press that is held produces exactly one event.
- R12: Exactly one digit is enabled at a time, and each digit stays enabled for `SCAN_CYCLES` cycles before the scan moves to the next index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (board reset button) |
| btn_act_i | input | 1 | Raw action button, active high |
| btn_mode_i | input | 1 | Raw mode button, active high |
| slv_tx_data | output | 4 | Word presented to the slave core for sending |
| slv_tx_vld | output | 1 | One-cycle load strobe to the slave core |
| slv_tx_rdy | input | 1 | Slave core can accept a word |
| slv_rx_data | input | 4 | Word received by the slave core |
| slv_rx_vld | input | 1 | Slave received word is valid |
| mst_tx_data | output | 4 | Word presented to the master core for sending |
| mst_tx_vld | output | 1 | One-cycle transfer start strobe to the master core |
| mst_tx_last | output | 1 | Last-word flag, so chip select releases after one word |
| mst_tx_rdy | input | 1 | Master core can accept a word |
| mst_rx_data | input | 4 | Word received by the master core |
| mst_rx_vld | input | 1 | Master received word is valid |
| seg_n | output | 7 | Segments {g,f,e,d,c,b,a}, active low |
| dp_n | output | 1 | Decimal point, active low |
| dig_n | output | 4 | Digit enables, active low, bit i is digit i |

## Verification
The single-cycle property of the valid strobes relies on action events being at least a debounce window apart, so that no new press can land in the cycle in which a strobe fires. The bench holds and releases every button for many times `DEB_CYCLES` to keep to this. The received-word hold properties assume the core models pulse valid only with meaningful data. The bench drives the receive pulses for single cycles and changes the data freely when no pulse is present. The ready inputs are moved only between presses, so each hold-off case is observed before and after ready returns.

// File: rtl/spi_loop_pkg.sv
package spi_loop_pkg;

    localparam int unsigned NIB_W   = 4;
    localparam int unsigned NUM_DIG = 4;
    localparam int unsigned IDX_W   = $clog2(NUM_DIG);

    typedef enum logic [1:0] {
        MODE_SLV_SET = 2'd0,
        MODE_SLV_ARM = 2'd1,
        MODE_MST_SET = 2'd2,
        MODE_XFER    = 2'd3
    } lb_mode_e;

    // Active-high glyph, bit order {g,f,e,d,c,b,a}
    function automatic logic [6:0] hex_glyph(input logic [NIB_W-1:0] v);
        logic [6:0] g;
        unique case (v)
            4'h0: g = 7'h3F;
            4'h1: g = 7'h06;
            4'h2: g = 7'h5B;
            4'h3: g = 7'h4F;
            4'h4: g = 7'h66;
            4'h5: g = 7'h6D;
            4'h6: g = 7'h7D;
            4'h7: g = 7'h07;
            4'h8: g = 7'h7F;
            4'h9: g = 7'h6F;
            4'hA: g = 7'h77;
            4'hB: g = 7'h7C;
            4'hC: g = 7'h39;
            4'hD: g = 7'h5E;
            4'hE: g = 7'h79;
            default: g = 7'h71;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/lb_btn_filter.sv
module lb_btn_filter #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DEB_CYCLES  = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic press_o
);
    localparam int unsigned CNT_W = $clog2(DEB_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(DEB_CYCLES - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   stable_q;
    logic [CNT_W-1:0]       cnt_q;
    logic                   press_q;
    logic                   synced;

    assign synced = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q   <= '0;
            stable_q <= 1'b0;
            cnt_q    <= '0;
            press_q  <= 1'b0;
        end else begin
            sync_q  <= {sync_q[SYNC_STAGES-2:0], raw_i};
            press_q <= 1'b0;
            if (synced != stable_q) begin
                if (cnt_q == CNT_TOP) begin
                    stable_q <= synced;
                    cnt_q    <= '0;
                    press_q  <= synced;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                cnt_q <= '0;
            end
        end
    end

    assign press_o = press_q;

endmodule

// File: rtl/lb_sequencer.sv
module lb_sequencer
    import spi_loop_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             act_ev,
    input  logic             mode_ev,
    input  logic             slv_rdy,
    input  logic             mst_rdy,
    output lb_mode_e         mode_o,
    output logic [NIB_W-1:0] slv_val_o,
    output logic [NIB_W-1:0] mst_val_o,
    output logic             slv_vld_o,
    output logic             mst_vld_o
);
    lb_mode_e         mode_q, mode_d;
    logic [NIB_W-1:0] slv_val_q, slv_val_d;
    logic [NIB_W-1:0] mst_val_q, mst_val_d;
    logic             slv_pend_q, slv_pend_d;
    logic             mst_pend_q, mst_pend_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q     <= MODE_SLV_SET;
            slv_val_q  <= '0;
            mst_val_q  <= '0;
            slv_pend_q <= 1'b0;
            mst_pend_q <= 1'b0;
        end else begin
            mode_q     <= mode_d;
            slv_val_q  <= slv_val_d;
            mst_val_q  <= mst_val_d;
            slv_pend_q <= slv_pend_d;
            mst_pend_q <= mst_pend_d;
        end
    end

    // Next-state and action decode
    always_comb begin
        mode_d     = mode_q;
        slv_val_d  = slv_val_q;
        mst_val_d  = mst_val_q;
        slv_pend_d = slv_pend_q & ~slv_rdy;
        mst_pend_d = mst_pend_q & ~mst_rdy;
        unique case (mode_q)
            MODE_SLV_SET: begin
                if (act_ev)  slv_val_d = slv_val_q + 1'b1;
                if (mode_ev) mode_d = MODE_SLV_ARM;
            end
            MODE_SLV_ARM: begin
                if (act_ev)  slv_pend_d = 1'b1;
                if (mode_ev) mode_d = MODE_MST_SET;
            end
            MODE_MST_SET: begin
                if (act_ev)  mst_val_d = mst_val_q + 1'b1;
                if (mode_ev) mode_d = MODE_XFER;
            end
            MODE_XFER: begin
                if (act_ev) begin
                    slv_pend_d = 1'b1;
                    mst_pend_d = 1'b1;
                end
                if (mode_ev) mode_d = MODE_SLV_SET;
            end
        endcase
    end

    // Outputs
    always_comb begin
        mode_o    = mode_q;
        slv_val_o = slv_val_q;
        mst_val_o = mst_val_q;
        slv_vld_o = slv_pend_q & slv_rdy;
        mst_vld_o = mst_pend_q & mst_rdy;
    end

endmodule

// File: rtl/lb_display.sv
module lb_display
    import spi_loop_pkg::*;
#(
    parameter int unsigned SCAN_CYCLES = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_DIG*NIB_W-1:0] vals_i,
    input  logic [IDX_W-1:0]         mode_i,
    output logic [6:0]               seg_n,
    output logic                     dp_n,
    output logic [NUM_DIG-1:0]       dig_n
);
    localparam int unsigned SC_W = $clog2(SCAN_CYCLES + 1);
    localparam logic [SC_W-1:0] SC_TOP = SC_W'(SCAN_CYCLES - 1);

    logic [SC_W-1:0]  scan_q;
    logic [IDX_W-1:0] idx_q;
    logic [NIB_W-1:0] cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            scan_q <= '0;
            idx_q  <= '0;
        end else if (scan_q == SC_TOP) begin
            scan_q <= '0;
            idx_q  <= idx_q + 1'b1;
        end else begin
            scan_q <= scan_q + 1'b1;
        end
    end

    assign cur   = vals_i[{idx_q, 2'b00} +: NIB_W];
    assign seg_n = ~hex_glyph(cur);
    assign dp_n  = ~(idx_q == mode_i);

    for (genvar g = 0; g < NUM_DIG; g++) begin : g_dig
        assign dig_n[g] = ~(idx_q == IDX_W'(g));
    end

endmodule

// File: rtl/spi_loop_tester.sv
module spi_loop_tester
    import spi_loop_pkg::*;
#(
    parameter int unsigned DEB_CYCLES  = 500000,
    parameter int unsigned SCAN_CYCLES = 50000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       btn_act_i,
    input  logic       btn_mode_i,
    output logic [3:0] slv_tx_data,
    output logic       slv_tx_vld,
    input  logic       slv_tx_rdy,
    input  logic [3:0] slv_rx_data,
    input  logic       slv_rx_vld,
    output logic [3:0] mst_tx_data,
    output logic       mst_tx_vld,
    output logic       mst_tx_last,
    input  logic       mst_tx_rdy,
    input  logic [3:0] mst_rx_data,
    input  logic       mst_rx_vld,
    output logic [6:0] seg_n,
    output logic       dp_n,
    output logic [3:0] dig_n
);
    logic             act_ev, mode_ev;
    lb_mode_e         cur_mode;
    logic [NIB_W-1:0] slv_rx_q, mst_rx_q;

    lb_btn_filter #(.SYNC_STAGES(2), .DEB_CYCLES(DEB_CYCLES)) u_act (
        .clk(clk), .rst(rst), .raw_i(btn_act_i), .press_o(act_ev)
    );
    lb_btn_filter #(.SYNC_STAGES(2), .DEB_CYCLES(DEB_CYCLES)) u_mode (
        .clk(clk), .rst(rst), .raw_i(btn_mode_i), .press_o(mode_ev)
    );

    lb_sequencer u_seq (
        .clk(clk), .rst(rst), .act_ev(act_ev), .mode_ev(mode_ev),
        .slv_rdy(slv_tx_rdy), .mst_rdy(mst_tx_rdy),
        .mode_o(cur_mode), .slv_val_o(slv_tx_data), .mst_val_o(mst_tx_data),
        .slv_vld_o(slv_tx_vld), .mst_vld_o(mst_tx_vld)
    );

    assign mst_tx_last = mst_tx_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            slv_rx_q <= '0;
            mst_rx_q <= '0;
        end else begin
            if (slv_rx_vld) slv_rx_q <= slv_rx_data;
            if (mst_rx_vld) mst_rx_q <= mst_rx_data;
        end
    end

    lb_display #(.SCAN_CYCLES(SCAN_CYCLES)) u_disp (
        .clk(clk), .rst(rst),
        .vals_i({mst_rx_q, mst_tx_data, slv_rx_q, slv_tx_data}),
        .mode_i(cur_mode),
        .seg_n(seg_n), .dp_n(dp_n), .dig_n(dig_n)
    );

endmodule

// File: rtl/spi_loop_tester_chk.sv
module spi_loop_tester_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode,
    input logic       act_ev,
    input logic       mode_ev,
    input logic [3:0] slv_tx_data,
    input logic [3:0] mst_tx_data,
    input logic       slv_tx_vld,
    input logic       slv_tx_rdy,
    input logic       mst_tx_vld,
    input logic       mst_tx_rdy,
    input logic       mst_tx_last,
    input logic       slv_rx_vld,
    input logic [3:0] slv_rx_q,
    input logic       mst_rx_vld,
    input logic [3:0] mst_rx_q,
    input logic [3:0] dig_n
);
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (mode == 2'd0 && slv_tx_data == 4'd0 && mst_tx_data == 4'd0 &&
                 !slv_tx_vld && !mst_tx_vld));

    p_mode_step_r2: assert property (@(posedge clk) disable iff (rst)
        mode_ev |=> mode == $past(mode) + 2'd1);

    p_mode_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !mode_ev |=> $stable(mode));

    p_slv_inc_r3: assert property (@(posedge clk) disable iff (rst)
        (act_ev && mode == 2'd0) |=> slv_tx_data == $past(slv_tx_data) + 4'd1);

    p_slv_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        slv_tx_vld |=> !slv_tx_vld);

    p_mst_inc_r5: assert property (@(posedge clk) disable iff (rst)
        (act_ev && mode == 2'd2) |=> mst_tx_data == $past(mst_tx_data) + 4'd1);

    p_last_r6: assert property (@(posedge clk) disable iff (rst)
        mst_tx_vld |-> mst_tx_last);

    p_slv_gate_r7: assert property (@(posedge clk) disable iff (rst)
        slv_tx_vld |-> slv_tx_rdy);

    p_mst_gate_r7: assert property (@(posedge clk) disable iff (rst)
        mst_tx_vld |-> mst_tx_rdy);

    p_slv_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !slv_rx_vld |=> $stable(slv_rx_q));

    p_mst_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !mst_rx_vld |=> $stable(mst_rx_q));

    p_evt_single_r11: assert property (@(posedge clk) disable iff (rst)
        act_ev |=> !act_ev);

    p_dig_one_r12: assert property (@(posedge clk) disable iff (rst)
        $countones(~dig_n) == 1);

endmodule

bind spi_loop_tester spi_loop_tester_chk u_chk (
    .clk(clk), .rst(rst), .mode(cur_mode), .act_ev(act_ev), .mode_ev(mode_ev),
    .slv_tx_data(slv_tx_data), .mst_tx_data(mst_tx_data),
    .slv_tx_vld(slv_tx_vld), .slv_tx_rdy(slv_tx_rdy),
    .mst_tx_vld(mst_tx_vld), .mst_tx_rdy(mst_tx_rdy), .mst_tx_last(mst_tx_last),
    .slv_rx_vld(slv_rx_vld), .slv_rx_q(slv_rx_q),
    .mst_rx_vld(mst_rx_vld), .mst_rx_q(mst_rx_q), .dig_n(dig_n)
);

// File: tb/tb_spi_loop_tester.sv
module tb_spi_loop_tester;
    localparam int DEB  = 4;
    localparam int SCAN = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic btn_act = 1'b0, btn_mode = 1'b0;
    logic [3:0] slv_tx_data, mst_tx_data, slv_rx_data = 4'd0, mst_rx_data = 4'd0;
    logic slv_tx_vld, mst_tx_vld, mst_tx_last;
    logic slv_tx_rdy = 1'b1, mst_tx_rdy = 1'b1;
    logic slv_rx_vld = 1'b0, mst_rx_vld = 1'b0;
    logic [6:0] seg_n;
    logic dp_n;
    logic [3:0] dig_n;

    int n_chk = 0, n_err = 0;
    int slv_cnt = 0, mst_cnt = 0, dbl_cnt = 0, last_bad = 0;
    logic [3:0] slv_seen = 4'd0;
    logic slv_prev = 1'b0;

    always #5 clk = ~clk;

    spi_loop_tester #(.DEB_CYCLES(DEB), .SCAN_CYCLES(SCAN)) dut (
        .clk(clk), .rst(rst), .btn_act_i(btn_act), .btn_mode_i(btn_mode),
        .slv_tx_data(slv_tx_data), .slv_tx_vld(slv_tx_vld), .slv_tx_rdy(slv_tx_rdy),
        .slv_rx_data(slv_rx_data), .slv_rx_vld(slv_rx_vld),
        .mst_tx_data(mst_tx_data), .mst_tx_vld(mst_tx_vld), .mst_tx_last(mst_tx_last),
        .mst_tx_rdy(mst_tx_rdy), .mst_rx_data(mst_rx_data), .mst_rx_vld(mst_rx_vld),
        .seg_n(seg_n), .dp_n(dp_n), .dig_n(dig_n)
    );

    // Core-side monitors
    always @(posedge clk) begin
        slv_prev <= slv_tx_vld;
        if (slv_tx_vld) begin
            slv_cnt  <= slv_cnt + 1;
            slv_seen <= slv_tx_data;
            if (slv_prev) dbl_cnt <= dbl_cnt + 1;
            if (!slv_tx_rdy) last_bad <= last_bad + 1;
        end
        if (mst_tx_vld) begin
            mst_cnt <= mst_cnt + 1;
            if (!mst_tx_last || !mst_tx_rdy) last_bad <= last_bad + 1;
        end
    end

    function automatic logic [6:0] glyph(input logic [3:0] v);
        case (v)
            4'h0: return 7'h3F; 4'h1: return 7'h06; 4'h2: return 7'h5B; 4'h3: return 7'h4F;
            4'h4: return 7'h66; 4'h5: return 7'h6D; 4'h6: return 7'h7D; 4'h7: return 7'h07;
            4'h8: return 7'h7F; 4'h9: return 7'h6F; 4'hA: return 7'h77; 4'hB: return 7'h7C;
            4'hC: return 7'h39; 4'hD: return 7'h5E; 4'hE: return 7'h79; default: return 7'h71;
        endcase
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic press(input bit is_mode, input int hold);
        @(negedge clk);
        if (is_mode) btn_mode = 1'b1; else btn_act = 1'b1;
        repeat (hold) @(negedge clk);
        btn_mode = 1'b0;
        btn_act  = 1'b0;
        repeat (20) @(negedge clk);
    endtask

    task automatic chk_digit(input string req, input int idx, input logic [3:0] v, input bit dp_on);
        logic [3:0] pat;
        bit found;
        pat = 4'b0001 << idx;
        found = 1'b0;
        for (int i = 0; i < 40 && !found; i++) begin
            @(negedge clk);
            if (dig_n == ~pat) found = 1'b1;
        end
        check(req, $sformatf("digit%0d enabled", idx), int'(found), 1);
        check(req, $sformatf("digit%0d seg_n", idx), int'(seg_n), int'(~glyph(v) & 7'h7F));
        check("R10", $sformatf("digit%0d dp_n", idx), int'(dp_n), dp_on ? 0 : 1);
    endtask

    task automatic t_reset();
        check("R1", "slv_tx_data", int'(slv_tx_data), 0);
        check("R1", "mst_tx_data", int'(mst_tx_data), 0);
        check("R1", "valid strobes", int'(slv_tx_vld | mst_tx_vld), 0);
        for (int d = 0; d < 4; d++) chk_digit("R1", d, 4'd0, d == 0);
    endtask

    task automatic t_mode_cycle();
        for (int m = 1; m <= 4; m++) begin
            press(1'b1, 20);
            for (int d = 0; d < 4; d++)
                chk_digit("R2", d, (d == 0 || d == 1 || d == 3) ? 4'd0 : mst_tx_data, d == (m % 4));
        end
    endtask

    task automatic t_slave_set();
        for (int i = 0; i < 3; i++) press(1'b0, 20);
        check("R3", "slave word after 3", int'(slv_tx_data), 3);
        chk_digit("R9", 0, 4'd3, 1'b1);
        for (int i = 0; i < 13; i++) press(1'b0, 20);
        check("R3", "slave word wraps", int'(slv_tx_data), 0);
        for (int i = 0; i < 5; i++) press(1'b0, 20);
        check("R3", "slave word after 5", int'(slv_tx_data), 5);
        check("R3", "master word untouched", int'(mst_tx_data), 0);
    endtask

    task automatic t_debounce();
        press(1'b0, 2);
        check("R11", "short pulse ignored", int'(slv_tx_data), 5);
        press(1'b0, 80);
        check("R11", "long hold one event", int'(slv_tx_data), 6);
    endtask

    task automatic t_slave_load();
        press(1'b1, 20);
        press(1'b0, 20);
        check("R4", "slave strobes", slv_cnt, 1);
        check("R4", "slave strobe data", int'(slv_seen), 6);
        check("R4", "double-cycle strobes", dbl_cnt, 0);
        check("R4", "no master strobe", mst_cnt, 0);
        check("R4", "slave word unchanged", int'(slv_tx_data), 6);
    endtask

    task automatic t_holdoff_slave();
        slv_tx_rdy = 1'b0;
        press(1'b0, 20);
        repeat (30) @(negedge clk);
        check("R7", "no strobe while busy", slv_cnt, 1);
        slv_tx_rdy = 1'b1;
        repeat (5) @(negedge clk);
        check("R7", "strobe after ready", slv_cnt, 2);
    endtask

    task automatic t_master_set();
        press(1'b1, 20);
        press(1'b0, 20);
        press(1'b0, 20);
        check("R5", "master word", int'(mst_tx_data), 2);
        check("R5", "no strobes in mode 2", mst_cnt, 0);
        chk_digit("R9", 2, 4'd2, 1'b1);
    endtask

    task automatic t_transfer();
        press(1'b1, 20);
        press(1'b0, 20);
        check("R6", "slave strobes", slv_cnt, 3);
        check("R6", "master strobes", mst_cnt, 1);
        check("R6", "last flag and ready", last_bad, 0);
        mst_tx_rdy = 1'b0;
        press(1'b0, 20);
        repeat (30) @(negedge clk);
        check("R7", "master held off", mst_cnt, 1);
        mst_tx_rdy = 1'b1;
        repeat (5) @(negedge clk);
        check("R7", "master issued", mst_cnt, 2);
        check("R6", "slave strobes again", slv_cnt, 4);
        chk_digit("R10", 3, 4'd0, 1'b1);
    endtask

    task automatic t_receive();
        @(negedge clk);
        slv_rx_data = 4'hA; slv_rx_vld = 1'b1;
        mst_rx_data = 4'hC; mst_rx_vld = 1'b1;
        @(negedge clk);
        slv_rx_vld = 1'b0; mst_rx_vld = 1'b0;
        slv_rx_data = 4'h1; mst_rx_data = 4'h7;
        repeat (4) @(negedge clk);
        chk_digit("R8", 1, 4'hA, 1'b0);
        chk_digit("R8", 3, 4'hC, 1'b1);
        chk_digit("R9", 0, 4'd6, 1'b0);
        chk_digit("R9", 2, 4'd2, 1'b0);
    endtask

    task automatic t_scan();
        logic [3:0] prev;
        int run, bad;
        bad = 0;
        @(negedge clk);
        prev = dig_n;
        while (dig_n == prev) @(negedge clk);
        prev = dig_n;
        run = 0;
        while (dig_n == prev) begin
            run++;
            if ($countones(~dig_n) != 1) bad++;
            @(negedge clk);
        end
        check("R12", "digit dwell", run, SCAN);
        for (int i = 0; i < 40; i++) begin
            if ($countones(~dig_n) != 1) bad++;
            @(negedge clk);
        end
        check("R12", "one digit at a time", bad, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        t_reset();
        t_mode_cycle();
        t_slave_set();
        t_debounce();
        t_slave_load();
        t_holdoff_slave();
        t_master_set();
        t_transfer();
        t_receive();
        t_scan();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule